// File: doc/BRIEF.md
# Self-Clocked Serial ADC Frame Reader

This block sits on the host side of a delta-sigma converter whose serial port supplies its own bit clock. The host runs on a fast system clock. To read, it pulls an active-low select low and never drives the clock line. This makes the converter pick its internal clock. The block brings the converter's clock and data lines into the system clock domain through two-flop synchronizers. It reads the readiness flag that the converter places on the data line before any clock. It then collects a 32-bit word, MSB first, on the synchronized rising clock edges. The word appears on a parallel output together with a one-cycle strobe, and the select is released in the same cycle.

Two other kinds of transaction are supported. A peek samples the readiness flag once, reports it, and releases the select before the converter starts clocking, so the converter stays asleep and keeps its result. An abort releases the select before the first clock edge. A watchdog ends a transaction when the converter stops producing clock edges. Between transactions the select stays high for a programmable minimum time.

Top module: `adc_frame_reader`

## Requirements
- R1: `sck_oe_o` is 0 in every cycle. After reset `cs_n_o` is 1 and no strobe (`frame_valid_o`, `peek_done_o`, `timeout_o`) is active.
- R2: A `start_i` pulse in the idle state drives `cs_n_o` low at the next clock edge. Data-line values present while `cs_n_o` is high produce no strobe.
- R3: The flag is sampled 4 cycles after select falls. Flag 0 means ready, and the block waits for clock edges. Flag 1 means busy, and the block waits for the flag to fall and then for clock edges. Both paths yield the same word.
- R4: Exactly 32 bits are taken, one on each synchronized rising edge of `sck_i`. The first bit taken lands in `frame_o[31]` and the last in `frame_o[0]`.
- R5: After the 32nd rising edge, `frame_valid_o` is high for exactly one cycle with the word on `frame_o`, and `cs_n_o` is high in that same cycle.
- R6: In a peek (`peek_i` high with `start_i`), the flag is sampled once. `peek_done_o` pulses with `peek_ready_o` = 1 when the flag read 0 and 0 when it read 1. `cs_n_o` rises with the pulse, before any rising clock edge.
- R7: `abort_i` while `cs_n_o` is low and before the first rising clock edge raises `cs_n_o` at the next edge with no strobe. Once bits are being taken, `abort_i` has no effect.
- R8: If no synchronized rising edge arrives within `to_limit_i` cycles while the block waits for one after a ready flag, `timeout_o` pulses and `cs_n_o` rises.
- R9: `start_i` is ignored unless the block is idle, so each transaction makes exactly one falling edge on `cs_n_o`.
- R10: `cs_n_o` stays high for at least `gap_limit_i` cycles between transactions, including the first one after reset.
- R11: At most one of the three strobes is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a transaction |
| peek_i | input | 1 | With start_i: readiness check only |
| abort_i | input | 1 | Cancel before first clock edge |
| to_limit_i | input | TMR_W | Watchdog limit in system cycles |
| gap_limit_i | input | TMR_W | Minimum select-high time in cycles |
| sck_i | input | 1 | Serial clock from converter (asynchronous) |
| sdo_i | input | 1 | Serial data from converter (asynchronous) |
| cs_n_o | output | 1 | Active-low converter select |
| sck_oe_o | output | 1 | Clock-line drive enable, held off |
| frame_o | output | FRAME_BITS | Captured word |
| frame_valid_o | output | 1 | One-cycle word strobe |
| peek_done_o | output | 1 | One-cycle peek result strobe |
| peek_ready_o | output | 1 | Peek result: 1 = result ready |
| timeout_o | output | 1 | One-cycle watchdog strobe |

## Verification
The hardest case to reach from the ports is the window between the select falling and the first clock edge. Abort, peek and watchdog each behave differently there, and a normal read passes through that window without any event. The bench uses a behavioural converter model with a configurable busy time, a delay before clocking, and a clock enable. This stretches the window to tens of cycles, so aborts, peeks, and the held-off clock for the watchdog land inside it. A second abort is timed from the model's own edge count, so that it falls inside the shifting phase.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [2:0] {
    ST_GAP,
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT_EOC,
    ST_WAIT_EDGE,
    ST_SHIFT
  } afr_state_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_FRAME,
    EV_PEEK,
    EV_TIMEOUT
  } afr_event_e;
endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/afr_capture.sv
module afr_capture #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  en_i,
  input  logic                  sck_s_i,
  input  logic                  bit_i,
  output logic                  rise_o,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic                  sck_d_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic                  take;

  assign rise_o = sck_s_i & ~sck_d_q;
  assign take   = rise_o & en_i;
  assign done_o = take && (cnt_q == LAST);
  assign word_o = {shreg_q[FRAME_BITS-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d_q <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sck_d_q <= sck_s_i;
      if (clr_i) begin
        cnt_q   <= '0;
        shreg_q <= '0;
      end else if (take) begin
        shreg_q <= word_o;
        cnt_q   <= cnt_q + ONE;
      end
    end
  end
endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             peek_i,
  input  logic             abort_i,
  input  logic             flag_s_i,
  input  logic             sck_rise_i,
  input  logic             frame_done_i,
  input  logic [TMR_W-1:0] to_limit_i,
  input  logic [TMR_W-1:0] gap_limit_i,
  output logic             cs_n_o,
  output logic             shift_en_o,
  output logic             cap_clr_o,
  output logic             peek_done_o,
  output logic             peek_ready_o,
  output logic             timeout_o
);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] ONE         = TMR_W'(1);

  afr_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             peek_q;

  assign shift_en_o = (state_q == ST_WAIT_EDGE) || (state_q == ST_SHIFT);
  assign cap_clr_o  = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_GAP;
      tmr_q        <= '0;
      peek_q       <= 1'b0;
      cs_n_o       <= 1'b1;
      peek_done_o  <= 1'b0;
      peek_ready_o <= 1'b0;
      timeout_o    <= 1'b0;
    end else begin
      peek_done_o <= 1'b0;
      timeout_o   <= 1'b0;
      case (state_q)
        ST_GAP: begin
          cs_n_o <= 1'b1;
          if (tmr_q >= gap_limit_i) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + ONE;
          end
        end
        ST_IDLE: begin
          if (start_i) begin
            cs_n_o  <= 1'b0;
            peek_q  <= peek_i;
            state_q <= ST_SETTLE;
            tmr_q   <= '0;
          end
        end
        ST_SETTLE: begin
          if (abort_i) begin
            cs_n_o  <= 1'b1;
            state_q <= ST_GAP;
            tmr_q   <= '0;
          end else if (tmr_q == SETTLE_LAST) begin
            tmr_q <= '0;
            if (peek_q) begin
              peek_done_o  <= 1'b1;
              peek_ready_o <= ~flag_s_i;
              cs_n_o       <= 1'b1;
              state_q      <= ST_GAP;
            end else if (flag_s_i) begin
              state_q <= ST_WAIT_EOC;
            end else begin
              state_q <= ST_WAIT_EDGE;
            end
          end else begin
            tmr_q <= tmr_q + ONE;
          end
        end
        ST_WAIT_EOC: begin
          if (abort_i) begin
            cs_n_o  <= 1'b1;
            state_q <= ST_GAP;
            tmr_q   <= '0;
          end else if (!flag_s_i) begin
            state_q <= ST_WAIT_EDGE;
            tmr_q   <= '0;
          end
        end
        ST_WAIT_EDGE: begin
          if (abort_i) begin
            cs_n_o  <= 1'b1;
            state_q <= ST_GAP;
            tmr_q   <= '0;
          end else if (sck_rise_i) begin
            state_q <= ST_SHIFT;
            tmr_q   <= '0;
          end else if (tmr_q == to_limit_i) begin
            timeout_o <= 1'b1;
            cs_n_o    <= 1'b1;
            state_q   <= ST_GAP;
            tmr_q     <= '0;
          end else begin
            tmr_q <= tmr_q + ONE;
          end
        end
        ST_SHIFT: begin
          if (frame_done_i) begin
            cs_n_o  <= 1'b1;
            state_q <= ST_GAP;
            tmr_q   <= '0;
          end else if (sck_rise_i) begin
            tmr_q <= '0;
          end else if (tmr_q == to_limit_i) begin
            timeout_o <= 1'b1;
            cs_n_o    <= 1'b1;
            state_q   <= ST_GAP;
            tmr_q     <= '0;
          end else begin
            tmr_q <= tmr_q + ONE;
          end
        end
        default: begin
          cs_n_o  <= 1'b1;
          state_q <= ST_GAP;
          tmr_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int FRAME_BITS  = 32,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  peek_i,
  input  logic                  abort_i,
  input  logic [TMR_W-1:0]      to_limit_i,
  input  logic [TMR_W-1:0]      gap_limit_i,
  input  logic                  sck_i,
  input  logic                  sdo_i,
  output logic                  cs_n_o,
  output logic                  sck_oe_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_valid_o,
  output logic                  peek_done_o,
  output logic                  peek_ready_o,
  output logic                  timeout_o
);
  logic [1:0]            sync_q;
  logic                  sck_s;
  logic                  sdo_s;
  logic                  sck_rise;
  logic                  frame_done;
  logic                  shift_en;
  logic                  cap_clr;
  logic [FRAME_BITS-1:0] word_next;

  assign sck_oe_o = 1'b0;

  afr_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({sck_i, sdo_i}),
    .q_o (sync_q)
  );
  assign sck_s = sync_q[1];
  assign sdo_s = sync_q[0];

  afr_capture #(.FRAME_BITS(FRAME_BITS)) cap_i (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (cap_clr),
    .en_i    (shift_en),
    .sck_s_i (sck_s),
    .bit_i   (sdo_s),
    .rise_o  (sck_rise),
    .done_o  (frame_done),
    .word_o  (word_next)
  );

  afr_ctrl #(.TMR_W(TMR_W), .SETTLE_CYC(SETTLE_CYC)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .peek_i       (peek_i),
    .abort_i      (abort_i),
    .flag_s_i     (sdo_s),
    .sck_rise_i   (sck_rise),
    .frame_done_i (frame_done),
    .to_limit_i   (to_limit_i),
    .gap_limit_i  (gap_limit_i),
    .cs_n_o       (cs_n_o),
    .shift_en_o   (shift_en),
    .cap_clr_o    (cap_clr),
    .peek_done_o  (peek_done_o),
    .peek_ready_o (peek_ready_o),
    .timeout_o    (timeout_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= frame_done;
      if (frame_done) frame_o <= word_next;
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int FRAME_BITS = 32,
  parameter int TMR_W      = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             abort_i,
  input logic [TMR_W-1:0] gap_limit_i,
  input logic             sck_i,
  input logic             cs_n_o,
  input logic             frame_valid_o,
  input logic             peek_done_o,
  input logic             timeout_o
);
  localparam int RC_W = $clog2(FRAME_BITS + 2);
  localparam logic [RC_W-1:0] RC_MAX = '1;

  logic [TMR_W:0]  gap_cnt_q;
  logic [RC_W-1:0] rise_cnt_q;
  logic            sck_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt_q  <= '0;
      rise_cnt_q <= '0;
      sck_prev_q <= 1'b1;
    end else begin
      sck_prev_q <= sck_i;
      if (cs_n_o) begin
        if (gap_cnt_q != '1) gap_cnt_q <= gap_cnt_q + 1'b1;
        rise_cnt_q <= '0;
      end else begin
        gap_cnt_q <= '0;
        if (sck_i && !sck_prev_q && rise_cnt_q != RC_MAX)
          rise_cnt_q <= rise_cnt_q + 1'b1;
      end
    end
  end

  p_gap_min_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (gap_cnt_q >= {1'b0, gap_limit_i}));

  p_frame_edges_r4: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> (rise_cnt_q == RC_W'(FRAME_BITS)));

  p_valid_release_r5: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> cs_n_o);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |=> !frame_valid_o);

  p_peek_no_edge_r6: assert property (@(posedge clk) disable iff (rst)
    peek_done_o |-> (cs_n_o && rise_cnt_q == '0));

  p_abort_release_r7: assert property (@(posedge clk) disable iff (rst)
    (abort_i && !cs_n_o && rise_cnt_q == '0) |=> cs_n_o);

  p_timeout_release_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> cs_n_o);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_valid_o, peek_done_o, timeout_o}));

  p_strobe_short_r11: assert property (@(posedge clk) disable iff (rst)
    (peek_done_o || timeout_o) |=> !(peek_done_o || timeout_o));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .FRAME_BITS(FRAME_BITS),
  .TMR_W     (TMR_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .abort_i       (abort_i),
  .gap_limit_i   (gap_limit_i),
  .sck_i         (sck_i),
  .cs_n_o        (cs_n_o),
  .frame_valid_o (frame_valid_o),
  .peek_done_o   (peek_done_o),
  .timeout_o     (timeout_o)
);

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
  localparam int FB    = 32;
  localparam int TW    = 16;
  localparam int GAP   = 20;
  localparam int TOLIM = 200;
  localparam int HALF  = 4;
  localparam int DELAY = 40;

  localparam logic [1:0] K_FRAME = 2'd1;
  localparam logic [1:0] K_PEEK  = 2'd2;
  localparam logic [1:0] K_TOUT  = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, peek_i = 1'b0, abort_i = 1'b0;
  logic [TW-1:0] to_limit_i  = TW'(TOLIM);
  logic [TW-1:0] gap_limit_i = TW'(GAP);
  logic sck_i = 1'b1, sdo_i = 1'b1;
  logic cs_n_o, sck_oe_o, frame_valid_o, peek_done_o, peek_ready_o, timeout_o;
  logic [FB-1:0] frame_o;

  always #5 clk = ~clk;

  adc_frame_reader dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .peek_i(peek_i), .abort_i(abort_i),
    .to_limit_i(to_limit_i), .gap_limit_i(gap_limit_i), .sck_i(sck_i), .sdo_i(sdo_i),
    .cs_n_o(cs_n_o), .sck_oe_o(sck_oe_o), .frame_o(frame_o),
    .frame_valid_o(frame_valid_o), .peek_done_o(peek_done_o),
    .peek_ready_o(peek_ready_o), .timeout_o(timeout_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // converter model
  logic [31:0] m_word   = 32'h0;
  int          m_busy   = 0;
  bit          m_clk_en = 1'b1;
  int          ms = 0, bcnt = 0, dcnt = 0, hc = 0, rises = 0;
  int          total_rises = 0;

  always @(negedge clk) begin
    if (rst || cs_n_o) begin
      ms    <= 0;
      sck_i <= 1'b1;
      sdo_i <= 1'($urandom % 2);
      rises <= 0;
    end else begin
      case (ms)
        0: begin
          sck_i <= 1'b0;
          if (m_busy > 0) begin
            sdo_i <= 1'b1; bcnt <= m_busy; ms <= 1;
          end else begin
            sdo_i <= m_word[31]; dcnt <= DELAY; ms <= 2;
          end
        end
        1: if (bcnt <= 1) begin
             sdo_i <= m_word[31]; dcnt <= DELAY; ms <= 2;
           end else bcnt <= bcnt - 1;
        2: if (m_clk_en) begin
             if (dcnt <= 1) begin ms <= 3; hc <= 0; end
             else dcnt <= dcnt - 1;
           end
        3: if (hc == HALF - 1) begin
             hc <= 0;
             if (!sck_i) begin
               sck_i <= 1'b1;
               rises <= rises + 1;
               total_rises <= total_rises + 1;
               if (rises + 1 == FB) ms <= 4;
             end else begin
               sck_i <= 1'b0;
               sdo_i <= m_word[31 - rises];
             end
           end else hc <= hc + 1;
        default: ;
      endcase
    end
  end

  // scoreboard
  typedef struct packed { logic [1:0] kind; logic [31:0] data; } exp_t;
  exp_t exp_q[$];
  int   ev_count = 0;
  int   cs_falls = 0;
  int   high_run = 0;
  int   last_run = 0;
  bit   prev_strobe = 1'b0;
  bit   oe_bad = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sck_oe_o !== 1'b0) oe_bad = 1'b1;
      if (cs_n_o) high_run++;
      else if (high_run > 0) begin
        cs_falls++;
        last_run = high_run;
        check(high_run >= GAP, "R10", "select high time", high_run, GAP);
        high_run = 0;
      end
      if (frame_valid_o || peek_done_o || timeout_o) begin
        logic [1:0] k;
        exp_t e;
        ev_count++;
        check(($countones({frame_valid_o, peek_done_o, timeout_o}) == 1) && !prev_strobe,
              "R11", "strobe exclusive and single", {frame_valid_o, peek_done_o, timeout_o}, 0);
        k = frame_valid_o ? K_FRAME : (peek_done_o ? K_PEEK : K_TOUT);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected event", k, 0);
        end else begin
          e = exp_q.pop_front();
          check(k == e.kind, "R5", "event kind", k, e.kind);
          if (k == K_FRAME && e.kind == K_FRAME)
            check(frame_o == e.data, "R4", "frame word", frame_o, e.data);
          if (k == K_PEEK && e.kind == K_PEEK)
            check(peek_ready_o == e.data[0], "R6", "peek ready", peek_ready_o, e.data[0]);
        end
        prev_strobe = 1'b1;
      end else prev_strobe = 1'b0;
    end
  end

  task automatic pulse_start(input bit pk);
    @(negedge clk); start_i = 1'b1; peek_i = pk;
    @(negedge clk); start_i = 1'b0; peek_i = 1'b0;
    check(cs_n_o == 1'b0, "R2", "select low after start", cs_n_o, 0);
  endtask

  task automatic wait_events(input int target);
    while (ev_count < target) @(negedge clk);
  endtask

  // mid: 0 none, 1 abort after 5 rises, 2 start after 3 rises
  task automatic run_txn(input logic [1:0] kind, input logic [31:0] word,
                         input int busy, input bit clk_en, input int mid);
    int base_ev, base_r;
    exp_t e;
    m_word = word; m_busy = busy; m_clk_en = clk_en;
    e.kind = kind;
    e.data = (kind == K_PEEK) ? {31'd0, busy == 0} : word;
    exp_q.push_back(e);
    base_ev = ev_count;
    base_r  = total_rises;
    pulse_start(kind == K_PEEK);
    if (mid != 0) begin
      while (total_rises < base_r + ((mid == 1) ? 5 : 3)) @(negedge clk);
      @(negedge clk);
      if (mid == 1) abort_i = 1'b1; else start_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0; start_i = 1'b0;
    end
    wait_events(base_ev + 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n_o == 1'b1, "R1", "select after reset", cs_n_o, 1);
    check(sck_oe_o == 1'b0, "R1", "clock drive after reset", sck_oe_o, 0);
    check({frame_valid_o, peek_done_o, timeout_o} == 3'b000, "R1", "strobes after reset",
          {frame_valid_o, peek_done_o, timeout_o}, 0);
    repeat (GAP + 5) @(negedge clk);

    // R3 R4 R5: ready flag, several patterns
    run_txn(K_FRAME, 32'h1234_5678, 0, 1'b1, 0);
    repeat (GAP + 5) @(negedge clk);
    run_txn(K_FRAME, 32'h5A5A_A5A5, 60, 1'b1, 0);   // R3 busy path
    repeat (GAP + 5) @(negedge clk);
    run_txn(K_FRAME, 32'h7FFF_FFFE, 0, 1'b1, 0);
    repeat (GAP + 5) @(negedge clk);
    run_txn(K_FRAME, 32'h0000_0001, 25, 1'b1, 0);
    repeat (GAP + 5) @(negedge clk);

    // R6 peek ready, no clock edges, result kept
    begin
      int r0;
      r0 = total_rises;
      run_txn(K_PEEK, 32'h4321_8765, 0, 1'b1, 0);
      check(total_rises == r0, "R6", "edges during peek", total_rises - r0, 0);
      repeat (GAP + 5) @(negedge clk);
      run_txn(K_FRAME, 32'h4321_8765, 0, 1'b1, 0);
      repeat (GAP + 5) @(negedge clk);
    end
    run_txn(K_PEEK, 32'h0, 500, 1'b1, 0);          // R6 busy
    repeat (GAP + 5) @(negedge clk);

    // R7 abort while busy
    begin
      int e0;
      e0 = ev_count;
      m_busy = 200; m_word = 32'h0; m_clk_en = 1'b1;
      pulse_start(1'b0);
      repeat (10) @(negedge clk);
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      check(cs_n_o == 1'b1, "R7", "select after abort", cs_n_o, 1);
      repeat (100) @(negedge clk);
      check(ev_count == e0, "R7", "events after abort", ev_count - e0, 0);
    end

    // R7 abort after shifting began is ignored
    run_txn(K_FRAME, 32'h0BAD_F00D, 0, 1'b1, 1);
    repeat (GAP + 5) @(negedge clk);

    // R9 start during frame ignored
    begin
      int f0;
      f0 = cs_falls;
      run_txn(K_FRAME, 32'h3C3C_0FF0, 0, 1'b1, 2);
      repeat (GAP + 40) @(negedge clk);
      check(cs_falls == f0 + 1, "R9", "select falls per transaction", cs_falls - f0, 1);
    end

    // R8 timeout with converter holding its clock
    run_txn(K_TOUT, 32'h0, 0, 1'b0, 0);
    check(cs_n_o == 1'b1, "R8", "select after timeout", cs_n_o, 1);

    // R10 start held right after a transaction
    begin
      exp_t e;
      m_clk_en = 1'b1; m_busy = 0; m_word = 32'h2468_ACE0;
      e.kind = K_FRAME; e.data = 32'h2468_ACE0;
      exp_q.push_back(e);
      start_i = 1'b1;
      while (cs_n_o) @(negedge clk);
      start_i = 1'b0;
      check(last_run >= GAP, "R10", "held start waits gap", last_run, GAP);
      wait_events(ev_count + 1);
    end

    // R2 noise on data line while select high
    begin
      int e0;
      e0 = ev_count;
      repeat (150) @(negedge clk);
      check(ev_count == e0 && cs_n_o, "R2", "idle events with noise", ev_count - e0, 0);
    end

    check(!oe_bad, "R1", "clock drive enable stayed off", oe_bad, 0);
    check(exp_q.size() == 0, "R5", "outstanding expectations", exp_q.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule